// File: doc/BRIEF.md
# Push-Button Power and Reset Sequencer

This block is the control core of a power-management controller. It decides when the main supply rails are enabled, and when the processor's reset is held or released, from two decoded button events and two signals from the processor and the rail. A push-button press while the system is off enables the rails. The processor must then claim the supply with either of its two hold requests before the button is let go. If the button is released first, the block treats the press as accidental and turns the rails off again.

Reset is released only after a programmable number of clock cycles, the time-out, has passed with the monitored rail reporting power-good. A separate manual-reset event pulls reset low at once, through a path with no register in it. Reset is released again only after that event has ended and a full time-out has passed. An active-low status line mirrors the button at all times. All asynchronous inputs pass through two-flop synchronizers before they reach the state machine.

The power state machine has three states: OFF (rails off), ARMED (rails on, waiting for a hold request) and ON (rails held by the processor). It has four transitions:
- PRESS: OFF to ARMED, on a synchronized button press.
- GRAB: ARMED to ON, when any hold request is seen. GRAB has priority over ABORT in the same cycle.
- ABORT: ARMED to OFF, when the button is released with no hold request.
- DROP: ON to OFF, when both hold requests are low.

Top module: `pb_power_seq`

## Requirements
- R1: During reset and in the first cycle after it, `rail_en_o` is 0, `reset_n_o` is 0 and `btn_stat_n_o` is 1, with all inputs low.
- R2: With the block in OFF, a button press that is held enables the rail. `rail_en_o` goes high after exactly the third rising clock edge following the input change (two synchronizer stages plus the state register).
- R3: In ARMED, releasing the button while neither hold request is asserted returns the block to OFF. `rail_en_o` goes low after exactly the third rising edge following the release.
- R4: Once either hold request (`hold_a_i` or `hold_b_i`) has been seen, releasing the button does not change `rail_en_o`. This also holds when a hold request was already high at the time of the press.
- R5: With the rail enabled and no manual reset, `reset_n_o` rises after exactly TIMEOUT_CYCLES+2 rising edges following the rising edge of `rail_good_i`.
- R6: If `rail_good_i` drops during the count, the count restarts. `reset_n_o` then rises only TIMEOUT_CYCLES+2 edges after `rail_good_i` last returns high.
- R7: While `mrst_press_i` is high, `reset_n_o` is low, with no clock edge needed.
- R8: After `mrst_press_i` falls, `reset_n_o` stays low for TIMEOUT_CYCLES+2 rising edges and then rises.
- R9: `btn_stat_n_o` is low exactly while `btn_press_i` or `mrst_press_i` is high, with no clock edge needed.
- R10: In ON, dropping both hold requests turns the rail off 3 edges later (DROP). `reset_n_o` is low in the same cycle in which `rail_en_o` falls.
- R11: A manual-reset event never changes `rail_en_o`, whether the block is in OFF or in ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_press_i | input | 1 | Decoded push-button press, active high, asynchronous |
| mrst_press_i | input | 1 | Decoded manual-reset press, active high, asynchronous |
| hold_a_i | input | 1 | First processor hold request, active high |
| hold_b_i | input | 1 | Second processor hold request, active high |
| rail_good_i | input | 1 | Power-good flag of the monitored rail |
| rail_en_o | output | 1 | Rail enable, high in ARMED and ON |
| reset_n_o | output | 1 | Processor reset, active low |
| btn_stat_n_o | output | 1 | Button status, low while either button input is high |

## Verification
The hardest situation to reach is a reset count that is cut short and then restarted. Reaching it needs the rail already enabled and held, a good flag that has been counting for part of the time-out, and a one-cycle dip that the synchronizer still catches. The stimulus first powers up under a hold request and completes a manual reset. It then drops the good flag part of the way through a fresh count and pulses it low for a single cycle. The time until reset releases is measured from the last rising edge of the good flag. A cycle-by-cycle behavioural model also tracks every output across each of these phases.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_ARMED = 2'd1,
        PS_ON    = 2'd2
    } pwr_state_t;

    function automatic logic state_powers_rail(input pwr_state_t st);
        return (st == PS_ARMED) || (st == PS_ON);
    endfunction

endpackage

// File: rtl/pbseq_sync.sv
module pbseq_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < int'(STAGES); s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/pbseq_rst_timer.sv
module pbseq_rst_timer #(
    parameter int unsigned LIMIT = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run_i) begin
            count_q <= '0;
        end else if (count_q != TOP) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign expired_o = (count_q == TOP);

endmodule

// File: rtl/pbseq_fsm.sv
module pbseq_fsm
    import pbseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press_i,
    input  logic hold_i,
    output logic rail_en_o
);
    pwr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF:   if (press_i) state_d = PS_ARMED;          // PRESS
            PS_ARMED: begin
                if (hold_i)        state_d = PS_ON;             // GRAB
                else if (!press_i) state_d = PS_OFF;            // ABORT
            end
            PS_ON:    if (!hold_i) state_d = PS_OFF;            // DROP
            default:               state_d = PS_OFF;
        endcase
    end

    always_comb begin
        rail_en_o = state_powers_rail(state_q);
    end

endmodule

// File: rtl/pb_power_seq.sv
module pb_power_seq #(
    parameter int unsigned TIMEOUT_CYCLES = 65536,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_press_i,
    input  logic mrst_press_i,
    input  logic hold_a_i,
    input  logic hold_b_i,
    input  logic rail_good_i,
    output logic rail_en_o,
    output logic reset_n_o,
    output logic btn_stat_n_o
);
    localparam int unsigned NSYNC = 5;

    logic [NSYNC-1:0] raw_in, syn_in;
    logic btn_s, mrst_s, hold_a_s, hold_b_s, good_s;
    logic rail_on, count_run, timed_out;

    assign raw_in = {rail_good_i, hold_b_i, hold_a_i, mrst_press_i, btn_press_i};

    pbseq_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign {good_s, hold_b_s, hold_a_s, mrst_s, btn_s} = syn_in;

    pbseq_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_i   (btn_s),
        .hold_i    (hold_a_s | hold_b_s),
        .rail_en_o (rail_on)
    );

    assign count_run = rail_on & good_s & ~mrst_s;

    pbseq_rst_timer #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (count_run),
        .expired_o (timed_out)
    );

    assign rail_en_o    = rail_on;
    assign reset_n_o    = timed_out & count_run & ~mrst_press_i;
    assign btn_stat_n_o = ~(btn_press_i | mrst_press_i);

endmodule

// File: rtl/pbseq_checker.sv
module pbseq_checker (
    input logic clk,
    input logic rst_n,
    input logic btn_press_i,
    input logic mrst_press_i,
    input logic hold_a_i,
    input logic hold_b_i,
    input logic rail_en_o,
    input logic reset_n_o
);
    assert_mrst_holds_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mrst_press_i |-> !reset_n_o);

    assert_rail_off_means_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_en_o |-> !reset_n_o);

    assert_rise_follows_press_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en_o) |-> $past(btn_press_i, 3));

    assert_fall_needs_no_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_en_o) |-> $past(!hold_a_i && !hold_b_i, 3));

    assert_release_needs_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_n_o) |-> rail_en_o);
endmodule

bind pb_power_seq pbseq_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_press_i  (btn_press_i),
    .mrst_press_i (mrst_press_i),
    .hold_a_i     (hold_a_i),
    .hold_b_i     (hold_b_i),
    .rail_en_o    (rail_en_o),
    .reset_n_o    (reset_n_o)
);

// File: tb/pb_power_seq_tb_top.sv
`timescale 1ns/1ps
module pb_power_seq_tb_top;
    localparam int LIM = 20;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, btn = 1'b0, mrst = 1'b0, ha = 1'b0, hb = 1'b0, good = 1'b0;
    logic rail_en, reset_n, stat_n;

    pb_power_seq #(.TIMEOUT_CYCLES(LIM), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_press_i(btn), .mrst_press_i(mrst),
        .hold_a_i(ha), .hold_b_i(hb), .rail_good_i(good),
        .rail_en_o(rail_en), .reset_n_o(reset_n), .btn_stat_n_o(stat_n)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: delay lines as queues, state as an integer
    bit q_b[$], q_m[$], q_a[$], q_h[$], q_g[$];
    int m_st, m_cnt;
    bit m_hold, m_cond;

    function automatic bit dly(ref bit q[$]);
        return q[0];
    endfunction

    task automatic model_clear();
        q_b = '{0, 0}; q_m = '{0, 0}; q_a = '{0, 0}; q_h = '{0, 0}; q_g = '{0, 0};
        m_st = 0; m_cnt = 0;
    endtask

    initial model_clear();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            m_hold = dly(q_a) | dly(q_h);
            m_cond = (m_st != 0) && dly(q_g) && !dly(q_m);
            m_cnt  = !m_cond ? 0 : (m_cnt < LIM ? m_cnt + 1 : m_cnt);
            if (m_st == 0 && dly(q_b))       m_st = 1;
            else if (m_st == 1 && m_hold)    m_st = 2;
            else if (m_st == 1 && !dly(q_b)) m_st = 0;
            else if (m_st == 2 && !m_hold)   m_st = 0;
            void'(q_b.pop_front()); q_b.push_back(btn);
            void'(q_m.pop_front()); q_m.push_back(mrst);
            void'(q_a.pop_front()); q_a.push_back(ha);
            void'(q_h.pop_front()); q_h.push_back(hb);
            void'(q_g.pop_front()); q_g.push_back(good);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_rail, e_rst, e_stat;
            e_rail = (m_st != 0);
            e_rst  = (m_cnt == LIM) && (m_st != 0) && dly(q_g) && !dly(q_m) && !mrst;
            e_stat = !(btn || mrst);
            check(rail_en == e_rail, "R2 model rail_en", int'(rail_en), int'(e_rail));
            check(reset_n == e_rst,  "R5 model reset_n", int'(reset_n), int'(e_rst));
            check(stat_n == e_stat,  "R9 model btn_stat_n", int'(stat_n), int'(e_stat));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // sel 0: rail high, 1: rail low, 2: reset released
    task automatic measure(input int sel, output int n);
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (sel == 0 && rail_en) break;
            if (sel == 1 && !rail_en) break;
            if (sel == 2 && reset_n) break;
            if (n > 1000) break;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(rail_en == 0, "R1 rail_en after reset", int'(rail_en), 0);
        check(reset_n == 0, "R1 reset_n after reset", int'(reset_n), 0);
        check(stat_n == 1,  "R1 btn_stat_n after reset", int'(stat_n), 1);

        tick(1); mrst = 1;                        // R11 manual reset while OFF
        tick(6);
        check(rail_en == 0, "R11 rail stays off on manual reset", int'(rail_en), 0);
        mrst = 0; tick(4);

        btn = 1; measure(0, n);                   // R2
        check(n == 3, "R2 press-to-rail edges", n, 3);
        tick(1); btn = 0; measure(1, n);          // R3 abort
        check(n == 3, "R3 release-to-off edges", n, 3);

        tick(3); btn = 1; measure(0, n);
        tick(1); good = 1; ha = 1; measure(2, n); // R5
        check(n == LIM + 2, "R5 good-to-release edges", n, LIM + 2);
        tick(1); btn = 0; tick(8);
        check(rail_en == 1, "R4 rail stays after release with hold", int'(rail_en), 1);

        mrst = 1; #0.5;                           // R7 R9
        check(reset_n == 0, "R7 reset low without edge", int'(reset_n), 0);
        check(stat_n == 0,  "R9 status low on manual reset", int'(stat_n), 0);
        tick(5);
        check(rail_en == 1, "R11 rail stays on during manual reset", int'(rail_en), 1);
        mrst = 0; measure(2, n);                  // R8
        check(n == LIM + 2, "R8 manual-release edges", n, LIM + 2);

        tick(1); good = 0; tick(4); good = 1;     // R6 restart
        tick(LIM / 2); good = 0; tick(1); good = 1;
        measure(2, n);
        check(n == LIM + 2, "R6 restart after good dip", n, LIM + 2);

        tick(1); btn = 1; #0.5;
        check(stat_n == 0, "R9 status low on button", int'(stat_n), 0);
        btn = 0; #0.5;
        check(stat_n == 1, "R9 status high after button", int'(stat_n), 1);

        tick(1); hb = 1; tick(1); ha = 0; tick(6);
        check(rail_en == 1, "R4 second hold keeps rail", int'(rail_en), 1);
        hb = 0; measure(1, n);                    // R10 drop
        check(n == 3, "R10 drop edges", n, 3);
        check(reset_n == 0, "R10 reset low with rail off", int'(reset_n), 0);

        tick(2); hb = 1; tick(1); btn = 1; measure(0, n);
        check(n == 3, "R2 press with hold already high", n, 3);
        tick(4); btn = 0; tick(6);
        check(rail_en == 1, "R4 pre-asserted hold keeps rail", int'(rail_en), 1);
        hb = 0; good = 0; tick(8);
        check(rail_en == 0, "R10 rail off after hold drop", int'(rail_en), 0);

        finish_run();
    end
endmodule